// File: doc/BRIEF.md
# Link Transmit Frame Assembler

This block sits between a transmit word queue and a line encoder. It reads tagged words from the queue and wraps them into frames. Each frame starts with a start control word, carries payload words of one type, and ends with an end control word. A frame may start only when the queue holds a word, the retransmit queue is empty and the far end is not asking this node to back off. Those two gates are checked only between frames. A frame that has started is never cut short by them.

Each queued word carries a type tag: ordinary data, sync primitive, or software-data-valid primitive. All three types travel the same path and are framed the same way. A data frame carries at most 2048 payload bytes, which is 512 words at the default 32-bit width. A primitive frame carries at most one word. A frame closes early when the queue runs dry or when the next queued word has a different type.

The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the presented word and its control flag hold still and nothing is taken from the queue. The input side is also valid/ready. A queue word is consumed, with `in_ready` high, only in the cycle its payload copy is accepted downstream. The control pins `rtx_empty` and `remote_backoff` are plain levels.

Top module: `link_tx_framer`

## Requirements
- R1: During and directly after reset, `out_valid` and `in_ready` are low.
- R2: With the queue empty (`in_valid` low) and no frame open, `out_valid` stays low.
- R3: With no frame open, while `rtx_empty` is low or `remote_backoff` is high, no frame starts: `out_valid` and `in_ready` stay low and no queue word is consumed.
- R4: The first word of every frame is a start control word. `out_ctrl` is 1, `out_word[1:0]` is the type of the frame's first queued word (0 data, 1 sync, 2 software-data-valid), `out_word[2]` is 0 and all higher bits are 0.
- R5: Payload words are the queued words in queue order, with `out_ctrl` at 0. `in_ready` is high exactly when a payload word is presented and `out_ready` is high.
- R6: A data frame carries at most DATA_MAX_BYTES/(WORD_W/8) payload words, which is 512 by default. With enough words queued, a frame holds exactly that many.
- R7: A sync or software-data-valid frame carries at most PRIM_MAX_WORDS payload words, which is 1 by default.
- R8: A frame closes with an end control word: `out_ctrl` 1, `out_word[2]` 1, `out_word[1:0]` the frame type, higher bits 0. It closes when the limit is reached, when the queue is empty, or when the head word's type differs from the frame type.
- R9: Changes on `rtx_empty` or `remote_backoff` while a frame is open do not alter or cut that frame.
- R10: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with the same `out_word` and `out_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transmit queue holds a word |
| in_ready | output | 1 | Pop the queue head this cycle |
| in_data | input | WORD_W | Queue head word |
| in_kind | input | 2 | Queue head type: 0 data, 1 sync, 2 software-data-valid |
| rtx_empty | input | 1 | Retransmit queue is empty |
| remote_backoff | input | 1 | Far end requests back-off |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Encoder accepts the output word |
| out_word | output | WORD_W | Control or payload word |
| out_ctrl | output | 1 | 1 marks a control word |

## Verification
Suppose the sequencer takes a wrong turn, for example by skipping the start word, entering a frame while gated, or missing an end word. The very next output cycle then shows a control flag or word value that differs from a reference stepping through the same queue contents. A frame-length count that drifts shows up only when a frame should have closed, at the 512th data word or the first primitive word. Full-length frames are therefore forced on purpose. A lost or doubled pop appears as the wrong payload value on the next accepted data word.

// File: rtl/ltf_pkg.sv
package ltf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOF  = 2'd1,
    ST_PAY  = 2'd2,
    ST_EOF  = 2'd3
  } ltf_state_e;

  localparam logic [1:0] KIND_DATA = 2'd0;
  localparam logic [1:0] KIND_SYNC = 2'd1;
  localparam logic [1:0] KIND_SWDV = 2'd2;

  function automatic logic kind_is_prim(input logic [1:0] k);
    return (k == KIND_SYNC) || (k == KIND_SWDV);
  endfunction

endpackage

// File: rtl/ltf_start_gate.sv
module ltf_start_gate (
  input  logic word_avail,
  input  logic rtx_empty,
  input  logic remote_backoff,
  output logic go
);
  // a frame may open only with a queued word, a drained retransmit path
  // and no back-off request from the far end
  assign go = word_avail & rtx_empty & ~remote_backoff;
endmodule

// File: rtl/ltf_len_counter.sv
module ltf_len_counter #(
  parameter int DATA_MAX_WORDS = 512,
  parameter int PRIM_MAX_WORDS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  input  logic prim,
  output logic room
);
  localparam int CNT_W = $clog2(DATA_MAX_WORDS + 1);
  localparam logic [CNT_W-1:0] DATA_LIM = CNT_W'(DATA_MAX_WORDS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] prim_lim;

  // the primitive limit never exceeds the data limit
  generate
    if (PRIM_MAX_WORDS < DATA_MAX_WORDS) begin : g_prim_own
      assign prim_lim = CNT_W'(PRIM_MAX_WORDS);
    end else begin : g_prim_clamp
      assign prim_lim = DATA_LIM;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (bump)  cnt_q <= cnt_q + 1'b1;
  end

  assign room = cnt_q < (prim ? prim_lim : DATA_LIM);
endmodule

// File: rtl/ltf_out_mux.sv
module ltf_out_mux
  import ltf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  ltf_state_e        state,
  input  logic [1:0]        kind,
  input  logic [WORD_W-1:0] head_data,
  input  logic              pay_ok,
  output logic              valid,
  output logic [WORD_W-1:0] word,
  output logic              ctrl
);
  always_comb begin
    valid = 1'b0;
    ctrl  = 1'b0;
    word  = '0;
    unique case (state)
      ST_SOF: begin
        valid     = 1'b1;
        ctrl      = 1'b1;
        word[1:0] = kind;
      end
      ST_PAY: begin
        valid = pay_ok;
        word  = head_data;
      end
      ST_EOF: begin
        valid     = 1'b1;
        ctrl      = 1'b1;
        word[2]   = 1'b1;
        word[1:0] = kind;
      end
      default: begin
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
  import ltf_pkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int DATA_MAX_BYTES = 2048,
  parameter int PRIM_MAX_WORDS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [1:0]        in_kind,
  input  logic              rtx_empty,
  input  logic              remote_backoff,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_ctrl
);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int DATA_MAX_WORDS = DATA_MAX_BYTES / BYTES_PER_WORD;

  ltf_state_e state_q, state_d;
  logic [1:0] kind_q;
  logic       go;
  logic       room;
  logic       pay_ok;

  ltf_start_gate u_gate (
    .word_avail     (in_valid),
    .rtx_empty      (rtx_empty),
    .remote_backoff (remote_backoff),
    .go             (go)
  );

  ltf_len_counter #(
    .DATA_MAX_WORDS (DATA_MAX_WORDS),
    .PRIM_MAX_WORDS (PRIM_MAX_WORDS)
  ) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_q == ST_SOF),
    .bump  (in_ready),
    .prim  (kind_is_prim(kind_q)),
    .room  (room)
  );

  // the head word joins the open frame only if its type matches and room is left
  assign pay_ok   = in_valid && (in_kind == kind_q) && room;
  assign in_ready = (state_q == ST_PAY) && pay_ok && out_ready;

  ltf_out_mux #(.WORD_W(WORD_W)) u_mux (
    .state     (state_q),
    .kind      (kind_q),
    .head_data (in_data),
    .pay_ok    (pay_ok),
    .valid     (out_valid),
    .word      (out_word),
    .ctrl      (out_ctrl)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go)         state_d = ST_SOF;
      ST_SOF:  if (out_ready)  state_d = ST_PAY;
      ST_PAY:  if (!pay_ok)    state_d = ST_EOF;
      ST_EOF:  if (out_ready)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_DATA;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go) kind_q <= in_kind;
    end
  end
endmodule

// File: rtl/ltf_checker.sv
module ltf_checker
  import ltf_pkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int DATA_MAX_WORDS = 512,
  parameter int PRIM_MAX_WORDS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_ctrl,
  input logic              in_ready,
  input logic              rtx_empty,
  input logic              remote_backoff,
  input ltf_state_e        state_q
);
  logic [15:0] fcnt;
  logic [1:0]  fkind;
  logic        fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt  <= '0;
      fkind <= KIND_DATA;
    end else if (fire && out_ctrl && !out_word[2]) begin
      fcnt  <= '0;
      fkind <= out_word[1:0];
    end else if (fire && !out_ctrl) begin
      fcnt  <= fcnt + 1'b1;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ctrl)); // R10

  AST_POP_WITH_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_valid && out_ready && !out_ctrl); // R5

  AST_GATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && (!rtx_empty || remote_backoff) |=> (state_q == ST_IDLE)); // R3

  AST_DATA_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !out_ctrl && !kind_is_prim(fkind) |-> fcnt < 16'(DATA_MAX_WORDS)); // R6

  AST_PRIM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !out_ctrl && kind_is_prim(fkind) |-> fcnt < 16'(PRIM_MAX_WORDS)); // R7

  AST_CTRL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ctrl |-> out_word[WORD_W-1:3] == '0); // R8
endmodule

bind link_tx_framer ltf_checker #(
  .WORD_W         (WORD_W),
  .DATA_MAX_WORDS (DATA_MAX_WORDS),
  .PRIM_MAX_WORDS (PRIM_MAX_WORDS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_word       (out_word),
  .out_ctrl       (out_ctrl),
  .in_ready       (in_ready),
  .rtx_empty      (rtx_empty),
  .remote_backoff (remote_backoff),
  .state_q        (state_q)
);

// File: tb/test_link_tx_framer.sv
module test_link_tx_framer;
  localparam int W = 32;
  localparam int DLIM = 512;
  localparam int PLIM = 1;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_data = '0;
  logic [1:0] in_kind = 2'd0;
  logic rtx_empty = 1'b1, remote_backoff = 1'b0;
  logic out_valid, out_ready = 1'b0, out_ctrl;
  logic [W-1:0] out_word;

  always #10 clk = ~clk;

  link_tx_framer i_link_tx_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_kind(in_kind), .rtx_empty(rtx_empty),
    .remote_backoff(remote_backoff), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ctrl(out_ctrl)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] qd [QN];
  logic [1:0]   qk [QN];
  int hd = 0, tl = 0;
  int ms = 0, mc = 0;
  logic [1:0] mk = 2'd0;
  int flen = 0, max_dlen = 0, max_plen = 0, prim_frames = 0;
  logic [1:0] fk = 2'd0;
  bit prev_stall = 0;
  logic [W-1:0] prev_word = '0;
  logic prev_ctrl = 1'b0;
  bit done = 0;

  function automatic int lim_of(input logic [1:0] k);
    return (k == 2'd1 || k == 2'd2) ? PLIM : DLIM;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [W-1:0] d, input logic [1:0] k);
    qd[tl % QN] = d;
    qk[tl % QN] = k;
    tl++;
  endtask

  task automatic step(input bit rdy, input bit rtx, input bit bo);
    int nms, nmc;
    logic [1:0] nmk;
    bit ev, ec, eir, pop, take;
    logic [W-1:0] ew;
    string tag;
    @(negedge clk);
    out_ready = rdy; rtx_empty = rtx; remote_backoff = bo;
    in_valid = (tl != hd);
    in_data = qd[hd % QN];
    in_kind = qk[hd % QN];
    #1;
    nms = ms; nmc = mc; nmk = mk; ev = 0; ec = 0; eir = 0; pop = 0; ew = '0;
    case (ms)
      0: begin
        if (tl != hd && rtx && !bo) begin nms = 1; nmk = qk[hd % QN]; end
        tag = (!rtx || bo) ? "R3" : "R2";
      end
      1: begin
        ev = 1; ec = 1; ew = {{(W-2){1'b0}}, mk};
        if (rdy) begin nms = 2; nmc = 0; end
        tag = "R4";
      end
      2: begin
        take = (tl != hd) && (qk[hd % QN] == mk) && (mc < lim_of(mk));
        if (take) begin
          ev = 1; ew = qd[hd % QN]; eir = rdy;
          if (rdy) begin nmc = mc + 1; pop = 1; end
        end else nms = 3;
        tag = "R5";
      end
      default: begin
        ev = 1; ec = 1; ew = {{(W-3){1'b0}}, 1'b1, mk};
        if (rdy) nms = 0;
        tag = "R8";
      end
    endcase
    if (ms != 0 && (bo || !rtx)) tag = {tag, "/R9"};
    chk(out_valid == ev, {tag, " out_valid"}, W'(out_valid), W'(ev));
    chk(in_ready == eir, {tag, " in_ready"}, W'(in_ready), W'(eir));
    if (ev) chk(out_ctrl == ec && out_word == ew, {tag, " word"}, out_word, ew);
    if (prev_stall)
      chk(out_valid && out_word == prev_word && out_ctrl == prev_ctrl, "R10 hold", out_word, prev_word);
    prev_stall = out_valid && !rdy;
    prev_word = out_word; prev_ctrl = out_ctrl;
    if (out_valid && rdy) begin
      if (out_ctrl && !out_word[2]) begin flen = 0; fk = out_word[1:0]; end
      else if (!out_ctrl) flen++;
      else begin
        if (fk == 2'd0) begin
          if (flen > max_dlen) max_dlen = flen;
          chk(flen <= DLIM, "R6 frame length", W'(flen), W'(DLIM));
        end else begin
          prim_frames++;
          if (flen > max_plen) max_plen = flen;
          chk(flen <= PLIM, "R7 frame length", W'(flen), W'(PLIM));
        end
      end
    end
    @(posedge clk); #1;
    ms = nms; mc = nmc; mk = nmk;
    if (pop) hd++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      chk(!out_valid && !in_ready, "R1 in reset", W'({out_valid, in_ready}), '0);
    end
    rst_n = 1'b1;
    // R1 right after reset, R2 empty queue
    repeat (5) step(1, 1, 0);
    // R3: words queued but gated by back-off, then by retransmit
    push(32'h1111_0001, 2'd0); push(32'h1111_0002, 2'd0); push(32'h1111_0003, 2'd0);
    repeat (8) step(1, 1, 1);
    repeat (8) step(1, 0, 0);
    chk(hd == 0, "R3 nothing consumed", W'(hd), '0);
    repeat (12) step(1, 1, 0);
    // R6: full data frame, with gates toggling mid-frame (R9)
    for (int i = 0; i < 600; i++) push(32'hA000_0000 + W'(i), 2'd0);
    for (int i = 0; i < 700; i++) step(1, (i % 7) != 3, (i % 11) == 5);
    repeat (40) step(1, 1, 0);
    chk(max_dlen == DLIM, "R6 full frame", W'(max_dlen), W'(DLIM));
    // R7 / R8: primitives and type changes
    push(32'h5150_0001, 2'd1); push(32'h5150_0002, 2'd1); push(32'h5D00_0003, 2'd2);
    push(32'hD000_0004, 2'd0); push(32'hD000_0005, 2'd0); push(32'h5150_0006, 2'd1);
    repeat (40) step(1, 1, 0);
    chk(max_plen == PLIM, "R7 primitive frame", W'(max_plen), W'(PLIM));
    chk(prim_frames == 4, "R7 primitive frame count", W'(prim_frames), 32'd4);
    chk(hd == tl, "R8 queue drained", W'(hd), W'(tl));
    // random mix with back-pressure (R10)
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if ($urandom % 2 == 0 && tl - hd < QN - 4)
        push($urandom, (r < 80) ? 2'd0 : (r < 90) ? 2'd1 : 2'd2);
      step(($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 7) == 0);
    end
    repeat (3000) begin
      step(1, 1, 0);
      if (hd == tl && ms == 0) break;
    end
    chk(hd == tl && ms == 0, "R8 drained after random", W'(tl - hd), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule